// File: doc/BRIEF.md
# Watchdog Timer with Service Code

This block watches for a processor that has stopped running its program. A free-running divider counts system clocks. One of its bits, chosen by a tap-select input, clocks a two-stage binary counter. Software must write the service byte 8'h4E to the service address before that counter overflows. If it does not, the block drives an active-low reset line for a fixed number of clocks, or it raises a one-cycle interrupt if that has been selected.

The block has two byte-wide write addresses. Address 0 holds the configuration: bit 0 is the run enable and bit 1 selects the interrupt. Address 1 is the service address. Every overflow restarts the divider and the counter from zero. A service write also restarts the divider, so the time to the next overflow is exact and does not depend on the divider phase.

Top module: `wdog_clrcode`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `wdt_rst_n` is 1 and `wdt_irq` is 0. Reset also returns the configuration to run=1 and interrupt select=0, which is reset mode.
- R2: Let b = TAP_LO + TAP_STEP*`tap_sel`. The counter advances each time divider bit b rises, and it overflows on the fourth rise. `wdt_rst_n` therefore falls 7*2^b clocks after the last restart edge. A restart edge is any of these: the last edge with reset high, an accepted service write, a write that turns run on, or the edge that ends a reset pulse.
- R3: A write to `wr_addr`=1 with data 8'h4E restarts the divider and the counter. If such a write lands on the same edge as an overflow, the write wins and no overflow is produced.
- R4: A write to `wr_addr`=1 with any other byte has no effect, so the original deadline still holds.
- R5: In reset mode, an overflow drives `wdt_rst_n` low for exactly PULSE_LEN clocks. Counting then restarts from zero.
- R6: A service write while `wdt_rst_n` is low changes neither the pulse length nor the following deadline.
- R7: When run (bit 0 at address 0) is 0, the counter holds at zero and no output fires. Writing run=1 makes that write a restart edge.
- R8: When interrupt select (bit 1 at address 0) is 1, an overflow gives a single-cycle `wdt_irq`, `wdt_rst_n` stays high, and counting restarts.
- R9: `wdt_irq` and a low `wdt_rst_n` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_sel | input | SEL_W | Divider tap that sets the detection time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration, 1 = service |
| wr_data | input | 8 | Write data |
| wdt_rst_n | output | 1 | Active-low reset request, registered |
| wdt_irq | output | 1 | One-cycle overflow interrupt, registered |

## Verification
The checks assume that `tap_sel` stays constant between restarts. A change in the middle of a window would move the deadline and break the timing rules. They also assume that `rst` starts high, so that the output registers hold known values before any property is evaluated.

The stimulus selects a tap only while reset is asserted, and it drives every write and reset on the falling clock edge. The deadline checks can therefore count whole cycles from a known restart edge. Each write lasts exactly one cycle, so every write produces exactly one restart edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] SVC_CODE    = 8'h4E;
  localparam int         CFG_RUN_BIT = 0;
  localparam int         CFG_IRQ_BIT = 1;

  typedef enum logic { REG_CFG = 1'b0, REG_SVC = 1'b1 } wdog_reg_e;

  typedef struct packed {
    logic irq_sel;
    logic run;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output wdog_cfg_t  cfg,
  output logic       kick,
  output logic       run_set
);
  logic cfg_wr;

  assign cfg_wr  = wr_en && (wdog_reg_e'(wr_addr) == REG_CFG);
  assign kick    = wr_en && (wdog_reg_e'(wr_addr) == REG_SVC) && (wr_data == SVC_CODE);
  // Raised when a write turns run on; the timing window starts at this edge.
  assign run_set = cfg_wr && wr_data[CFG_RUN_BIT] && !cfg.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.run     <= 1'b1;
      cfg.irq_sel <= 1'b0;
    end else if (cfg_wr) begin
      cfg.run     <= wr_data[CFG_RUN_BIT];
      cfg.irq_sel <= wr_data[CFG_IRQ_BIT];
    end
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int N_TAPS   = 4,
  parameter int TAP_LO   = 2,
  parameter int TAP_STEP = 2,
  localparam int SEL_W   = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int DIV_W   = TAP_LO + TAP_STEP * (N_TAPS - 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tick
);
  logic [DIV_W-1:0]  div_q;
  logic [N_TAPS-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst || zero) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // Each tap reports the cycle whose increment makes its bit rise.
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int B = TAP_LO + TAP_STEP * i;
    assign hit[i] = (div_q[B:0] == {1'b0, {B{1'b1}}});
  end

  assign tick = (int'(tap_sel) < N_TAPS) ? hit[tap_sel] : 1'b0;
endmodule

// File: rtl/wdog_stage_cnt.sv
module wdog_stage_cnt #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zero,
  input  logic tick,
  output logic ovf
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || zero) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign ovf = tick && (&cnt_q);
endmodule

// File: rtl/wdog_fire.sv
module wdog_fire #(
  parameter int PULSE_LEN = 8,
  localparam int PW       = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic irq_sel,
  output logic rst_n_q,
  output logic irq_q
);
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_q <= 1'b1;
      irq_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      irq_q <= fire && irq_sel;
      if (!rst_n_q) begin
        if (pcnt_q == '0) rst_n_q <= 1'b1;
        else              pcnt_q  <= pcnt_q - 1'b1;
      end else if (fire && !irq_sel) begin
        rst_n_q <= 1'b0;
        pcnt_q  <= PW'(PULSE_LEN - 1);
      end
    end
  end
endmodule

// File: rtl/wdog_clrcode.sv
module wdog_clrcode
  import wdog_pkg::*;
#(
  parameter int N_TAPS    = 4,
  parameter int TAP_LO    = 2,
  parameter int TAP_STEP  = 2,
  parameter int STAGES    = 2,
  parameter int PULSE_LEN = 8,
  localparam int SEL_W    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  output logic             wdt_rst_n,
  output logic             wdt_irq
);
  wdog_cfg_t cfg_q;
  logic      kick, run_set, tick, ovf, fire, zero, run_w, busy;

  assign run_w = cfg_q.run;
  assign busy  = !wdt_rst_n;
  // A service write wins over an overflow on the same edge.
  assign fire  = ovf && !kick && run_w && !busy;
  assign zero  = kick || run_set || !run_w || busy || fire;

  wdog_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg_q), .kick(kick), .run_set(run_set)
  );

  wdog_prescaler #(.N_TAPS(N_TAPS), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)) u_div (
    .clk(clk), .rst(rst), .zero(zero), .tap_sel(tap_sel), .tick(tick)
  );

  wdog_stage_cnt #(.STAGES(STAGES)) u_cnt (
    .clk(clk), .rst(rst), .zero(zero), .tick(tick), .ovf(ovf)
  );

  wdog_fire #(.PULSE_LEN(PULSE_LEN)) u_fire (
    .clk(clk), .rst(rst), .fire(fire), .irq_sel(cfg_q.irq_sel),
    .rst_n_q(wdt_rst_n), .irq_q(wdt_irq)
  );
endmodule

// File: rtl/wdog_clrcode_chk.sv
module wdog_clrcode_chk #(
  parameter int PULSE_LEN = 8,
  localparam int CW       = $clog2(PULSE_LEN + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       run,
  input logic       wdt_rst_n,
  input logic       wdt_irq
);
  logic [CW-1:0] low_cnt;
  logic          svc_hit;

  assign svc_hit = wr_en && wr_addr && (wr_data == 8'h4E);

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (!wdt_rst_n) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wdt_rst_n && !wdt_irq));

  // R3
  service_holds_off_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_hit && wdt_rst_n) |=> wdt_rst_n);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_n) |-> (low_cnt == CW'(PULSE_LEN)));

  // R7
  stopped_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && wdt_rst_n) |=> (wdt_rst_n && !wdt_irq));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |=> !wdt_irq);

  // R9
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(wdt_irq && !wdt_rst_n));
endmodule

bind wdog_clrcode wdog_clrcode_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run_w), .wdt_rst_n(wdt_rst_n), .wdt_irq(wdt_irq)
);

// File: tb/wdog_clrcode_bench.sv
module wdog_clrcode_bench;
  localparam int TLO = 2;
  localparam int TST = 2;
  localparam int PL  = 8;
  localparam int NV  = 8;
  // {tap_sel, cycles before the write, byte written to the service address}
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 16'd5,    8'h4E}, {8'd0, 16'd5,   8'h4F},
    {8'd1, 16'd50,   8'h4E}, {8'd1, 16'd50,  8'h00},
    {8'd2, 16'd100,  8'hCE}, {8'd2, 16'd300, 8'h4E},
    {8'd0, 16'd20,   8'hE4}, {8'd3, 16'd1000, 8'h4E}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tap_sel = '0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wdt_rst_n, wdt_irq;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  wdog_clrcode u_wdog_clrcode (
    .clk(clk), .rst(rst), .tap_sel(tap_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_rst_n(wdt_rst_n), .wdt_irq(wdt_irq)
  );

  function automatic int deadline(int sel);
    return 7 * (1 << (TLO + TST * sel));
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(int sel);
    rst = 1'b1;
    tap_sel = 2'(sel);
    wr_en = 1'b0;
    wait_n(2);
    rst = 1'b0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    wait_n(1);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f;
    @(negedge clk);
    // R1: outputs quiet in reset and right after it
    rst = 1'b1; wait_n(2);
    chk("R1 rst_n in reset", wdt_rst_n, 1'b1);
    chk("R1 irq in reset", wdt_irq, 1'b0);
    do_reset(0);
    chk("R1 rst_n after reset", wdt_rst_n, 1'b1);
    chk("R1 irq after reset", wdt_irq, 1'b0);

    // R2, R3, R4: table walk
    for (int i = 0; i < NV; i++) begin
      int sel, w;
      logic [7:0] d;
      sel = int'(VEC[i][31:24]);
      w   = int'(VEC[i][23:8]);
      d   = VEC[i][7:0];
      f   = deadline(sel);
      do_reset(sel);
      wait_n(w);
      wr(1'b1, d);
      if (d == 8'h4E) begin
        wait_n(f - w - 1);
        chk("R3 no fire at old deadline", wdt_rst_n, 1'b1);
        wait_n(w);
        chk("R3 high before new deadline", wdt_rst_n, 1'b1);
        wait_n(1);
        chk("R2 fires at new deadline", wdt_rst_n, 1'b0);
      end else begin
        wait_n(f - w - 2);
        chk("R4 high just before deadline", wdt_rst_n, 1'b1);
        wait_n(1);
        chk("R4 other byte ignored, fires", wdt_rst_n, 1'b0);
      end
    end

    // R3: service on the overflow edge wins
    f = deadline(0);
    do_reset(0);
    wait_n(f - 1);
    wr(1'b1, 8'h4E);
    chk("R3 coincident service", wdt_rst_n, 1'b1);
    wait_n(f - 1);
    chk("R3 high before next deadline", wdt_rst_n, 1'b1);
    wait_n(1);
    chk("R2 next deadline", wdt_rst_n, 1'b0);

    // R5, R6: pulse length with a service write during the pulse
    do_reset(0);
    wait_n(f - 1);
    chk("R2 high before deadline", wdt_rst_n, 1'b1);
    wait_n(1);
    chk("R5 pulse starts", wdt_rst_n, 1'b0);
    wr(1'b1, 8'h4E);
    wait_n(PL - 2);
    chk("R6 still low at pulse end", wdt_rst_n, 1'b0);
    wait_n(1);
    chk("R5 released after PULSE_LEN", wdt_rst_n, 1'b1);
    wait_n(f - 1);
    chk("R6 high before next deadline", wdt_rst_n, 1'b1);
    wait_n(1);
    chk("R5 restart deadline", wdt_rst_n, 1'b0);
    // R1: reset during pulse releases the line
    do_reset(0);
    chk("R1 reset ends pulse", wdt_rst_n, 1'b1);

    // R7: stopped watchdog stays silent, re-enable restarts timing
    wr(1'b0, 8'h00);
    wait_n(2000);
    chk("R7 stopped rst_n", wdt_rst_n, 1'b1);
    chk("R7 stopped irq", wdt_irq, 1'b0);
    wr(1'b0, 8'h01);
    wait_n(f - 1);
    chk("R7 high before deadline", wdt_rst_n, 1'b1);
    wait_n(1);
    chk("R7 fires after enable", wdt_rst_n, 1'b0);

    // R8, R9: interrupt mode
    do_reset(1);
    f = deadline(1);
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h03);
    wait_n(f - 1);
    chk("R8 irq low before deadline", wdt_irq, 1'b0);
    wait_n(1);
    chk("R8 irq pulse", wdt_irq, 1'b1);
    chk("R9 rst_n high with irq", wdt_rst_n, 1'b1);
    wait_n(1);
    chk("R8 irq one cycle", wdt_irq, 1'b0);
    wait_n(f - 2);
    chk("R8 irq low before repeat", wdt_irq, 1'b0);
    wait_n(1);
    chk("R8 irq repeats", wdt_irq, 1'b1);
    chk("R9 rst_n high on repeat", wdt_rst_n, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule